// File: doc/BRIEF.md
# Snapshot Status Shifter with CRC-5

This block is a serial read-out port for eight digital input states and three health flags. A host acts as an SPI controller in mode 0. When the host drives chip select low, the block freezes the input states and the flags. It computes a five-bit check code over them and shifts the frame out on a single data line, most significant bit first. A strap input selects a short frame or a long frame. The short frame carries only the eight inputs. The long frame adds the check code and the three flags.

The serial pins are asynchronous to the block. Chip select, the serial clock and the chain input are each synchronized to a system clock that runs at least four times faster than the serial clock. The edges of the serial clock are then detected in the system clock domain. When the local frame has been shifted out, the data line carries the bits that arrived on the chain input. Several devices can therefore be cascaded and read through one port. The frame of the farthest device arrives last.

Top module: `snap_status_shifter`

## Requirements
- R1: `sdo` is 1 during reset and whenever `cs_n` has been high for at least four system clocks.
- R2: The falling edge of `cs_n` captures `pin_state` and `flag_uvl`, `flag_ot` and `flag_uvh`. Changes to these inputs after that edge have no effect on the frame being read.
- R3: The first frame bit, `pin_state[7]`, appears on `sdo` before any serial clock edge arrives.
- R4: Each later bit appears after a falling edge of `sclk`, most significant first. A rising edge of `sclk` leaves `sdo` unchanged.
- R5: With `short_frame` low, the frame has 16 bits in this order: `pin_state[7]` down to `pin_state[0]`, then the check code bit 4 down to bit 0, then `flag_uvl`, `flag_ot` and `flag_uvh`.
- R6: The check code uses the generator x^5+x^4+x^2+1. It runs over the eight input bits (bit 7 first) followed by `flag_uvl`, `flag_ot` and `flag_uvh`. The register starts at zero and the result is not inverted, so an all-zero snapshot gives code 0.
- R7: With `short_frame` high, the local frame is `pin_state[7]` down to `pin_state[0]` only.
- R8: After the local frame (8 or 16 bits), `sdo` carries the `chain_in` values sampled on successive rising `sclk` edges, in the order they were sampled.
- R9: `sdo` shows the new value three system clocks after a `cs_n` edge, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select from the host, active low |
| sclk | input | 1 | Serial clock from the host |
| chain_in | input | 1 | Serial data from the next device in the chain |
| short_frame | input | 1 | 1 selects the 8-bit frame, 0 selects the 16-bit frame |
| pin_state | input | 8 | Input states to report |
| flag_uvl | input | 1 | Low supply-level flag |
| flag_ot | input | 1 | Over-temperature flag |
| flag_uvh | input | 1 | Upper supply-level flag |
| sdo | output | 1 | Serial data to the host |

## Verification
The assertions check on every cycle that `sdo` is high while chip select is idle. They also check that `sdo` changes only after a detected serial falling edge or a chip-select transition, and that a capture puts the top input bit on the line and the flags in the tail of the long frame. The check code value, the order of the whole frame, the freezing of the snapshot against later input changes, the chain pass-through in both frame lengths and the exact three-cycle latency can only be shown by the bench's transfers.

// File: rtl/snap_status_shifter.sv
module snap_status_shifter #(
  parameter int N_IN = 8,
  parameter int CRC_W = 5,
  parameter logic [CRC_W-1:0] CRC_POLY = 5'h15,
  parameter int N_FLG = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            sclk,
  input  logic            chain_in,
  input  logic            short_frame,
  input  logic [N_IN-1:0] pin_state,
  input  logic            flag_uvl,
  input  logic            flag_ot,
  input  logic            flag_uvh,
  output logic            sdo
);
  localparam int FRAME_W = N_IN + CRC_W + N_FLG;
  localparam int MSG_W = N_IN + N_FLG;
  localparam int SHORT_POS = FRAME_W - N_IN;

  logic [SYNC_STAGES-1:0] cs_pipe, ck_pipe, di_pipe;
  logic cs_s, ck_s, di_s, cs_d, ck_d, din_q, short_q;
  logic cs_fall, ck_rise, ck_fall;
  logic [N_FLG-1:0] flags;
  logic [FRAME_W-1:0] sh, sh_shift;

  function automatic logic [CRC_W-1:0] crc_of(input logic [MSG_W-1:0] msg);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = MSG_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ msg[i];
      c = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction

  assign flags = {flag_uvl, flag_ot, flag_uvh};
  assign cs_s = cs_pipe[SYNC_STAGES-1];
  assign ck_s = ck_pipe[SYNC_STAGES-1];
  assign di_s = di_pipe[SYNC_STAGES-1];

  assign cs_fall = cs_d & ~cs_s;
  assign ck_rise = ~cs_d & ~ck_d & ck_s;
  assign ck_fall = ~cs_d & ck_d & ~ck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe <= '1;
      ck_pipe <= '0;
      di_pipe <= '0;
      cs_d <= 1'b1;
      ck_d <= 1'b0;
    end else begin
      cs_pipe <= {cs_pipe[SYNC_STAGES-2:0], cs_n};
      ck_pipe <= {ck_pipe[SYNC_STAGES-2:0], sclk};
      di_pipe <= {di_pipe[SYNC_STAGES-2:0], chain_in};
      cs_d <= cs_s;
      ck_d <= ck_s;
    end
  end

  always_comb begin
    sh_shift = sh << 1;
    if (short_q) sh_shift[SHORT_POS] = din_q;
    else sh_shift[0] = din_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '1;
      din_q <= 1'b0;
      short_q <= 1'b0;
    end else begin
      if (ck_rise) din_q <= di_s;
      if (cs_fall) begin
        sh <= {pin_state, crc_of({pin_state, flags}), flags};
        short_q <= short_frame;
      end else if (ck_fall) begin
        sh <= sh_shift;
      end
    end
  end

  assign sdo = cs_d ? 1'b1 : sh[FRAME_W-1];
endmodule

// File: rtl/snap_status_shifter_chk.sv
module snap_status_shifter_chk #(
  parameter int N_IN = 8,
  parameter int N_FLG = 3,
  parameter int FRAME_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_n,
  input logic               sdo,
  input logic [N_IN-1:0]    pin_state,
  input logic [N_FLG-1:0]   flags,
  input logic               short_frame,
  input logic               cs_fall,
  input logic               ck_fall,
  input logic               cs_d,
  input logic               cs_s,
  input logic [FRAME_W-1:0] sh
);
  logic [2:0] hi_cnt, cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      cyc <= '0;
    end else begin
      hi_cnt <= !cs_n ? 3'd0 : (hi_cnt == 3'd7 ? hi_cnt : hi_cnt + 3'd1);
      cyc <= (cyc == 3'd7) ? cyc : cyc + 3'd1;
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt >= 3'd4 |-> sdo);

  // R4
  change_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd2 && !$stable(sdo)) |-> $past(ck_fall || cs_fall || (cs_d != cs_s)));

  // R3
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> sdo == $past(pin_state[N_IN-1]));

  // R5
  flag_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && !short_frame) |=> sh[N_FLG-1:0] == $past(flags));
endmodule

bind snap_status_shifter snap_status_shifter_chk #(
  .N_IN(N_IN), .N_FLG(N_FLG), .FRAME_W(FRAME_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .pin_state(pin_state),
  .flags(flags), .short_frame(short_frame), .cs_fall(cs_fall), .ck_fall(ck_fall),
  .cs_d(cs_d), .cs_s(cs_s), .sh(sh)
);

// File: tb/snap_status_shifter_test.sv
module snap_status_shifter_test;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, chain_in = 0, short_frame = 0;
  logic [7:0] pin_state = 0;
  logic flag_uvl = 0, flag_ot = 0, flag_uvh = 0;
  logic sdo;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  snap_status_shifter uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .chain_in(chain_in),
    .short_frame(short_frame), .pin_state(pin_state), .flag_uvl(flag_uvl),
    .flag_ot(flag_ot), .flag_uvh(flag_uvh), .sdo(sdo)
  );

  // {pin_state, uvl ot uvh, short_frame}
  localparam logic [11:0] VEC [6] = '{
    {8'hA5, 3'b000, 1'b0}, {8'h00, 3'b111, 1'b0}, {8'hFF, 3'b101, 1'b0},
    {8'h3C, 3'b010, 1'b0}, {8'h96, 3'b000, 1'b1}, {8'h01, 3'b110, 1'b1}
  };

  function automatic logic [4:0] ref_crc(input logic [10:0] msg);
    logic [15:0] r;
    r = {msg, 5'b0};
    for (int i = 15; i >= 5; i--)
      if (r[i]) r[i-:6] = r[i-:6] ^ 6'b110101;
    return r[4:0];
  endfunction

  function automatic logic [31:0] ref_frame(input logic [7:0] p, input logic [2:0] f,
                                            input logic m, input logic [7:0] up);
    if (m) return {16'b0, p, up};
    return {8'b0, p, ref_crc({p, f}), f, up};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] p, input logic [2:0] f, input logic m,
                      input logic [7:0] up, input int nb, input bit flip,
                      output logic [31:0] got, output bit rise_ok);
    logic [7:0] upq;
    tick(1);
    pin_state = p; {flag_uvl, flag_ot, flag_uvh} = f; short_frame = m;
    upq = up; chain_in = upq[7];
    tick(2);
    cs_n = 0;
    tick(4);
    got = 0; rise_ok = 1;
    for (int i = 0; i < nb; i++) begin
      got = {got[30:0], sdo};
      if (flip && i == 0) begin
        pin_state = ~p; {flag_uvl, flag_ot, flag_uvh} = ~f;
      end
      if (i < nb - 1) begin
        sclk = 1; tick(4);
        if (sdo !== got[0]) rise_ok = 0;
        sclk = 0; upq = {upq[6:0], 1'b0}; chain_in = upq[7];
        tick(4);
      end
    end
    cs_n = 1; chain_in = 0;
    tick(5);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] got;
    bit rok;
    tick(3);
    check("R1 reset", {31'b0, sdo}, 32'd1);
    rst_n = 1;
    tick(3);

    foreach (VEC[k]) begin
      logic [7:0] p; logic [2:0] f; logic m;
      {p, f, m} = VEC[k];
      xfer(p, f, m, 8'h00, m ? 8 : 16, 0, got, rok);
      check(m ? "R7 short frame" : "R5 R6 long frame", got,
            ref_frame(p, f, m, 8'h00) >> 8);
    end

    xfer(8'h00, 3'b000, 0, 8'h00, 16, 0, got, rok);
    check("R6 zero snapshot", got[4:0] >= 0 ? {27'b0, got[7:3]} : 32'd0, 32'd0);

    xfer(8'h5A, 3'b011, 0, 8'h00, 16, 1, got, rok);
    check("R2 snapshot frozen", got, ref_frame(8'h5A, 3'b011, 0, 8'h00) >> 8);
    check("R4 rising edge holds", {31'b0, rok}, 32'd1);
    check("R1 idle high", {31'b0, sdo}, 32'd1);

    xfer(8'hC3, 3'b100, 0, 8'hA5, 24, 0, got, rok);
    check("R8 chain long", got, ref_frame(8'hC3, 3'b100, 0, 8'hA5));
    xfer(8'h69, 3'b111, 1, 8'h3B, 16, 0, got, rok);
    check("R8 chain short", got, ref_frame(8'h69, 3'b111, 1, 8'h3B));

    tick(1);
    pin_state = 8'h7F; short_frame = 0;
    cs_n = 0;
    @(posedge clk); @(posedge clk); #1;
    check("R9 not early", {31'b0, sdo}, 32'd1);
    @(posedge clk); #1;
    check("R9 R3 first bit", {31'b0, sdo}, 32'd0);
    tick(1);
    cs_n = 1;
    @(posedge clk); @(posedge clk); @(posedge clk); #1;
    check("R9 R1 release", {31'b0, sdo}, 32'd1);
    tick(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule